// File: doc/BRIEF.md
# Double-Buffered PWM Channel

This block is a single pulse-width modulation channel driven by a free-running period counter. It produces a complementary pair of outputs with dead-time inserted before every rising edge. Period, duty and dead-time can each be retuned while the channel runs. Software writes land in shadow copies, and each shadow raises its own pending flag. A shadow is copied into the active register that shapes the waveform only at the end of a period, so every period on the outputs uses one consistent set of values.

A mode input selects free or coordinated commits. In free (asynchronous) mode, every period end commits all shadows. In coordinated (synchronous) mode, an external update controller sends one-cycle commit strobes. A strobe is remembered until the next period end and commits there. The duty value can be tied to the same strobe as period and dead-time, or it can follow a strobe of its own.

The write ports are plain register strobes and carry no valid/ready pair. Every write is accepted in the cycle it is presented, so there is no back-pressure.

Top module: `pwm_dbuf_channel`

## Requirements
- R1: The counter `cnt_o` steps by one each clock from 0 to active period minus 1, then returns to 0 on the next clock.
- R2: When 1 <= duty <= period-1, `pwm_h` is high exactly while dead-time <= count < duty. `pwm_l` is high exactly while duty+dead-time <= count < period. Dead-time is measured in counter clocks.
- R3: A write stores the value in that register's shadow and sets its pending flag. The active value, and hence the waveform, does not change before the current period ends.
- R4: In asynchronous mode (`sync_mode`=0), all three shadows are loaded into the active registers when the period ends. This clears the pending flags, and the new values apply from the count-0 cycle that follows.
- R5: When a register is written several times before a commit, only the last value written becomes active.
- R6: In synchronous mode (`sync_mode`=1), period and dead-time commit only at a period end that comes after, or coincides with, a `commit_pd` strobe. That strobe is then consumed, so a later write waits for a fresh strobe.
- R7: In synchronous mode with `duty_sep`=1, duty commits only at a period end after a `commit_duty` strobe. With `duty_sep`=0, duty commits together with period and dead-time on `commit_pd`.
- R8: A write in the same cycle as a commit leaves its pending flag set. The active register takes the earlier shadow value, and the new value commits at the following period end.
- R9: Reset forces period 16, duty 8 and dead-time 2 (the default parameters) into both the active and shadow registers. It also clears the pending flags, zeroes the counter and holds both outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_mode | input | 1 | 0: commit every period end; 1: commit on controller strobes |
| duty_sep | input | 1 | In synchronous mode, duty uses its own strobe `commit_duty` |
| per_wr | input | 1 | Period shadow write strobe |
| per_data | input | CW | Period value |
| duty_wr | input | 1 | Duty shadow write strobe |
| duty_data | input | CW | Duty value |
| dt_wr | input | 1 | Dead-time shadow write strobe |
| dt_data | input | CW | Dead-time value in counter clocks |
| commit_pd | input | 1 | Controller strobe for period and dead-time |
| commit_duty | input | 1 | Controller strobe for duty |
| cnt_o | output | CW | Current counter value |
| pwm_h | output | 1 | High-side output |
| pwm_l | output | 1 | Complementary low-side output |
| per_pend | output | 1 | Period shadow awaiting commit |
| duty_pend | output | 1 | Duty shadow awaiting commit |
| dt_pend | output | 1 | Dead-time shadow awaiting commit |

## Verification
A shadow write and the period-end commit can occur in the same clock cycle. The bench provokes this by writing duty in the last count of a period. It then judges the result at the ports: the pending flag must stay set, the next period must still show the earlier duty, and the period after that must show the new duty. A controller strobe can also coincide with a period end. Its effect is judged by whether the following period takes the new length and the pending flag drops.

// File: rtl/pwm_dbuf_pkg.sv
package pwm_dbuf_pkg;
  localparam int NREG    = 3;
  localparam int IX_PER  = 0;
  localparam int IX_DUTY = 1;
  localparam int IX_DT   = 2;
endpackage

// File: rtl/pwm_shadow_reg.sv
module pwm_shadow_reg #(
  parameter int          W   = 8,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         commit,
  output logic [W-1:0] active,
  output logic         pend
);
  logic [W-1:0] shadow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow <= RST;
      active <= RST;
      pend   <= 1'b0;
    end else begin
      if (commit) active <= shadow;
      if (wr)     shadow <= wdata;
      if (wr)          pend <= 1'b1;
      else if (commit) pend <= 1'b0;
    end
  end

  AST_WRITE_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> pend); // R3
  AST_ACTIVE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(active)); // R3
  AST_COMMIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !wr) |=> !pend); // R4
  AST_LATE_WRITE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && wr) |=> (pend && shadow != active || pend)); // R8
endmodule

// File: rtl/pwm_commit_ctrl.sv
module pwm_commit_ctrl
  import pwm_dbuf_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            period_end,
  input  logic            sync_mode,
  input  logic            duty_sep,
  input  logic            commit_pd,
  input  logic            commit_duty,
  output logic [NREG-1:0] commit_o
);
  logic armed_pd, armed_duty;
  logic pd_go, duty_go;

  assign pd_go   = !sync_mode || armed_pd || commit_pd;
  assign duty_go = !sync_mode || (duty_sep ? (armed_duty || commit_duty) : pd_go);

  always_comb begin
    commit_o          = '0;
    commit_o[IX_PER]  = period_end && pd_go;
    commit_o[IX_DT]   = period_end && pd_go;
    commit_o[IX_DUTY] = period_end && duty_go;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_pd   <= 1'b0;
      armed_duty <= 1'b0;
    end else if (!sync_mode) begin
      armed_pd   <= 1'b0;
      armed_duty <= 1'b0;
    end else begin
      if (period_end && pd_go)                 armed_pd <= 1'b0;
      else if (commit_pd)                      armed_pd <= 1'b1;
      if (period_end && duty_sep && duty_go)   armed_duty <= 1'b0;
      else if (commit_duty)                    armed_duty <= 1'b1;
    end
  end

  AST_STROBE_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_mode && commit_o[IX_PER]) |=> !armed_pd); // R6
endmodule

// File: rtl/pwm_deadtime_out.sv
module pwm_deadtime_out #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          raw,
  input  logic [CW-1:0] dt,
  output logic          h_o,
  output logic          l_o
);
  logic          raw_q;
  logic [CW-1:0] age_q, age;
  logic          changed;

  assign changed = raw != raw_q;
  assign age     = changed ? '0 : ((&age_q) ? age_q : age_q + 1'b1);
  assign h_o     =  raw && (age >= dt);
  assign l_o     = !raw && (age >= dt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= 1'b0;
      age_q <= '0;
    end else begin
      raw_q <= raw;
      age_q <= age;
    end
  end

  AST_DEAD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (dt != '0 && $rose(h_o)) |-> !$past(l_o)); // R2
endmodule

// File: rtl/pwm_dbuf_channel.sv
module pwm_dbuf_channel
  import pwm_dbuf_pkg::*;
#(
  parameter int CW       = 8,
  parameter int PER_RST  = 16,
  parameter int DUTY_RST = 8,
  parameter int DT_RST   = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sync_mode,
  input  logic          duty_sep,
  input  logic          per_wr,
  input  logic [CW-1:0] per_data,
  input  logic          duty_wr,
  input  logic [CW-1:0] duty_data,
  input  logic          dt_wr,
  input  logic [CW-1:0] dt_data,
  input  logic          commit_pd,
  input  logic          commit_duty,
  output logic [CW-1:0] cnt_o,
  output logic          pwm_h,
  output logic          pwm_l,
  output logic          per_pend,
  output logic          duty_pend,
  output logic          dt_pend
);
  logic [CW-1:0]   cnt;
  logic            period_end;
  logic [NREG-1:0] wr_v, commit_v, pend_v;
  logic [CW-1:0]   wdat [NREG];
  logic [CW-1:0]   act  [NREG];

  assign wr_v[IX_PER]  = per_wr;
  assign wr_v[IX_DUTY] = duty_wr;
  assign wr_v[IX_DT]   = dt_wr;
  assign wdat[IX_PER]  = per_data;
  assign wdat[IX_DUTY] = duty_data;
  assign wdat[IX_DT]   = dt_data;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam int          RV_I = (g == IX_PER) ? PER_RST : (g == IX_DUTY) ? DUTY_RST : DT_RST;
    localparam logic [CW-1:0] RV = CW'(RV_I);
    pwm_shadow_reg #(.W(CW), .RST(RV)) u_reg (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (wr_v[g]),
      .wdata  (wdat[g]),
      .commit (commit_v[g]),
      .active (act[g]),
      .pend   (pend_v[g])
    );
  end

  assign period_end = ({1'b0, cnt} + (CW+1)'(1)) >= {1'b0, act[IX_PER]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (period_end) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

  pwm_commit_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .period_end  (period_end),
    .sync_mode   (sync_mode),
    .duty_sep    (duty_sep),
    .commit_pd   (commit_pd),
    .commit_duty (commit_duty),
    .commit_o    (commit_v)
  );

  pwm_deadtime_out #(.CW(CW)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .raw   (cnt < act[IX_DUTY]),
    .dt    (act[IX_DT]),
    .h_o   (pwm_h),
    .l_o   (pwm_l)
  );

  assign cnt_o     = cnt;
  assign per_pend  = pend_v[IX_PER];
  assign duty_pend = pend_v[IX_DUTY];
  assign dt_pend   = pend_v[IX_DT];

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |=> (cnt == '0)); // R1
  AST_PERIOD_MIDHOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !period_end |=> $stable(act[IX_PER])); // R3
endmodule

// File: tb/tb_pwm_dbuf_channel.sv
module tb_pwm_dbuf_channel;
  localparam int CW = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sync_mode = 0, duty_sep = 0, commit_pd = 0, commit_duty = 0;
  logic per_wr = 0, duty_wr = 0, dt_wr = 0;
  logic [CW-1:0] per_data = '0, duty_data = '0, dt_data = '0;
  logic [CW-1:0] cnt_o;
  logic pwm_h, pwm_l, per_pend, duty_pend, dt_pend;

  int nchk = 0, nfail = 0;
  int m_per = 16, m_duty = 8, m_dt = 2;
  bit done = 0;

  // period, duty, dead-time
  localparam int VEC [5][3] = '{'{10, 3, 0}, '{15, 14, 1}, '{15, 1, 0}, '{6, 4, 1}, '{12, 6, 3}};

  always #2.5 clk = ~clk;

  pwm_dbuf_channel #(.CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode), .duty_sep(duty_sep),
    .per_wr(per_wr), .per_data(per_data), .duty_wr(duty_wr), .duty_data(duty_data),
    .dt_wr(dt_wr), .dt_data(dt_data), .commit_pd(commit_pd), .commit_duty(commit_duty),
    .cnt_o(cnt_o), .pwm_h(pwm_h), .pwm_l(pwm_l),
    .per_pend(per_pend), .duty_pend(duty_pend), .dt_pend(dt_pend));

  task automatic check(int act, int exp, string req);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d at t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic check_outs(string req);
    int c = int'(cnt_o);
    check(int'(pwm_h), int'(c >= m_dt && c < m_duty), {req, " pwm_h"});
    check(int'(pwm_l), int'(c >= m_duty + m_dt && c < m_per), {req, " pwm_l"});
  endtask

  // at a negedge with cnt 0: walk one whole period against the model
  task automatic check_period(string req);
    for (int i = 0; i < m_per; i++) begin
      check(int'(cnt_o), i, {req, " cnt"});
      check_outs(req);
      @(negedge clk);
    end
    check(int'(cnt_o), 0, {req, " wrap"});
  endtask

  task automatic wait_cnt(int v);
    while (int'(cnt_o) != v) @(negedge clk);
  endtask

  task automatic finish_old(string req);
    while (cnt_o != '0) begin
      check_outs(req);
      @(negedge clk);
    end
  endtask

  task automatic wr_all(int p, int d, int t);
    per_wr = 1; duty_wr = 1; dt_wr = 1;
    per_data = CW'(p); duty_data = CW'(d); dt_data = CW'(t);
    @(negedge clk);
    per_wr = 0; duty_wr = 0; dt_wr = 0;
  endtask

  task automatic wr_one(int which, int v);
    if (which == 0) begin per_wr = 1; per_data = CW'(v); end
    else if (which == 1) begin duty_wr = 1; duty_data = CW'(v); end
    else begin dt_wr = 1; dt_data = CW'(v); end
    @(negedge clk);
    per_wr = 0; duty_wr = 0; dt_wr = 0;
  endtask

  task automatic strobe(bit duty);
    if (duty) commit_duty = 1; else commit_pd = 1;
    @(negedge clk);
    commit_pd = 0; commit_duty = 0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    check(int'(cnt_o), 0, "R9 cnt");
    check(int'(per_pend) + int'(duty_pend) + int'(dt_pend), 0, "R9 pend");
    check(int'(pwm_h), 0, "R9 pwm_h");
    check(int'(pwm_l), 0, "R9 pwm_l");
    rst_n = 1;
    check_period("R9 defaults");

    // R1 R2 R3 R4: table walk in asynchronous mode
    for (int v = 0; v < 5; v++) begin
      wait_cnt(2);
      wr_all(VEC[v][0], VEC[v][1], VEC[v][2]);
      check(int'(per_pend) + int'(duty_pend) + int'(dt_pend), 3, "R3 pend set");
      finish_old("R3 old values");
      m_per = VEC[v][0]; m_duty = VEC[v][1]; m_dt = VEC[v][2];
      check(int'(per_pend) + int'(duty_pend) + int'(dt_pend), 0, "R4 pend clear");
      check_period("R2 R1 new values");
    end

    // R5: last write wins
    wait_cnt(2);
    wr_one(1, 5);
    wr_one(1, 7);
    finish_old("R5 old");
    m_duty = 7;
    check(int'(duty_pend), 0, "R5 pend");
    check_period("R5 last value");

    // R8: write in the commit cycle
    wait_cnt(m_per - 1);
    wr_one(1, 4);
    check(int'(duty_pend), 1, "R8 pend kept");
    check_period("R8 earlier shadow");
    m_duty = 4;
    check(int'(duty_pend), 0, "R8 pend clear");
    check_period("R8 later commit");

    // R6: synchronous period commit
    sync_mode = 1; duty_sep = 0;
    wait_cnt(2);
    wr_one(0, 8);
    finish_old("R6 old");
    check(int'(per_pend), 1, "R6 held without strobe");
    check_period("R6 old period");
    strobe(0);
    finish_old("R6 armed");
    m_per = 8;
    check(int'(per_pend), 0, "R6 committed");
    check_period("R6 new period");
    wait_cnt(2);
    wr_one(0, 10);
    finish_old("R6 consumed");
    check(int'(per_pend), 1, "R6 strobe consumed");
    check_period("R6 still old");

    // R7: separate duty strobe
    duty_sep = 1;
    wait_cnt(2);
    wr_one(1, 3);
    strobe(0);
    finish_old("R7 old");
    m_per = 10;
    check(int'(per_pend), 0, "R7 period committed");
    check(int'(duty_pend), 1, "R7 duty held");
    check_period("R7 period only");
    strobe(1);
    finish_old("R7 armed duty");
    m_duty = 3;
    check(int'(duty_pend), 0, "R7 duty committed");
    check_period("R7 duty applied");

    // R9: reset in operation
    wait_cnt(3);
    wr_one(2, 1);
    rst_n = 0;
    @(negedge clk);
    check(int'(cnt_o), 0, "R9 cnt");
    check(int'(dt_pend), 0, "R9 pend cleared");
    check(int'(pwm_h) + int'(pwm_l), 0, "R9 outputs low");
    sync_mode = 0; duty_sep = 0;
    rst_n = 1;
    m_per = 16; m_duty = 8; m_dt = 2;
    check_period("R9 defaults restored");

    done = 1;
    summary();
    $finish;
  end
endmodule